// File: doc/BRIEF.md
# Four-Channel Single-Address Byte DMA Controller

This block moves bytes between two serial controllers and system memory without ever holding the data itself. Each of its four channels is tied in hardware to one serial direction. Channels 0 and 2 take received bytes from serial channels 0 and 1 and write them to memory. Channels 1 and 3 read bytes from memory and hand them to the transmitters of serial channels 0 and 1. Every transfer is single-address: the controller drives only the memory address and a write/read strobe. The peripheral that owns the cycle learns this from its acknowledge and drives or takes the data bus directly.

Software programs each channel with a 24-bit memory address, a 16-bit byte count and an enable. It then lets the peripheral raise its request. Each granted request completes one byte in one bus cycle. The address steps up by one and the count steps down by one. When the last byte moves, the channel drops its own enable and sets a completion flag. That flag can drive the shared interrupt line.

When several channels request together, an arbiter picks one of them. It uses either a fixed order, where channel 0 is highest, or a rotating order, as software selects.

Top module: `sdma4_ctrl`

## Requirements
- R1: Register map (5-bit address): channel c occupies addresses 4c..4c+3. Offset 0 holds the 24-bit memory address, offset 1 holds the 16-bit byte count, offset 2 holds control (bit0 enable, bit1 interrupt enable) and offset 3 reads 0. Address 16 holds the completion flags in bits 3:0 and address 17 holds the priority mode in bit0. Every written field reads back on `reg_rdata` in the same cycle it is addressed.
- R2: A cycle granted to channel 0 or 2 drives `mem_write`=1, and a cycle granted to channel 1 or 3 drives `mem_write`=0.
- R3: In a granted cycle `mem_valid` is 1, `mem_addr` equals the channel's current address and only that channel's bit of `per_ack` is set, all in the same cycle as the request. Otherwise `mem_valid` and `per_ack` are 0.
- R4: After each byte the channel's address increases by 1, wrapping from 0xFFFFFF to 0x000000, and its count decreases by 1.
- R5: A count of 0 moves exactly 65536 bytes before the channel finishes.
- R6: On the byte that moves the channel's count from 1 to 0, the channel clears its enable bit and sets its completion flag. Later requests from its peripheral get no acknowledge and leave the address unchanged until software re-enables the channel.
- R7: Writing 1 to a bit of address 16 clears that completion flag, and writing 0 leaves it unchanged.
- R8: `irq` is 1 exactly when some channel has both its completion flag and its interrupt enable set.
- R9: At most one channel is acknowledged per cycle, and only while its request and enable are both set. If any enabled channel requests, one is granted.
- R10: With priority mode 0, the lowest-numbered enabled requesting channel is granted.
- R11: With priority mode 1, the search starts at the channel after the one granted most recently (channel 0 first after reset) and wraps from 3 to 0.
- R12: After reset all registers read 0, `irq` is 0 and no request is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for reads and writes |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data for `reg_addr` |
| per_req | input | 4 | Transfer request from each channel's peripheral |
| per_ack | output | 4 | Acknowledge selecting the peripheral for this bus cycle |
| mem_valid | output | 1 | A memory bus cycle is taking place |
| mem_write | output | 1 | 1 = peripheral data written to memory, 0 = memory read out to peripheral |
| mem_addr | output | 24 | Memory byte address of the cycle |
| irq | output | 1 | Completion interrupt |

## Verification
The embedded assertions check several rules on every cycle. The grant is one-hot and legal, and an eligible request is never left without a grant. Fixed mode never passes over a lower-numbered eligible channel. The bus direction follows the acknowledged channel's parity. A transfer always steps the address and count, and the last byte always drops the enable and raises the flag. Some behaviour only the bench scenarios can show: the rotation order of round-robin mode, the 24-bit address wrap and the full 65536-byte block, and the write-one-to-clear rules. The same applies to interrupt masking and to ignored requests after completion. All of these are compared against a cycle model that the bench keeps.

// File: rtl/sdma_pkg.sv
// Package: shared register offsets and helpers for the four-channel DMA.
// Assumes the channel count is a power of two.
package sdma_pkg;
    localparam logic [1:0] OFS_ADDR = 2'd0;
    localparam logic [1:0] OFS_CNT  = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;

    // Mask of channels that carry receive data into memory (even numbers).
    function automatic logic [31:0] rx_mask(input int n);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < n; i += 2) m[i] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/sdma_arbiter.sv
// Module: sdma_arbiter
// Picks one eligible channel per cycle, either in fixed order (0 highest)
// or rotating from the channel after the last grant. The grant is
// combinational. The rotation pointer is registered.
// Assumes NCH is a power of two so the pointer wraps by overflow.
module sdma_arbiter #(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] elig,
    input  logic           rr_mode,
    output logic [NCH-1:0] grant,
    output logic [CHW-1:0] gnt_idx,
    output logic           gnt_any
);
    logic [CHW-1:0] last_q;
    logic [CHW-1:0] cand;

    // Select the winning channel for this cycle.
    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = '0;
        cand    = '0;
        if (!rr_mode) begin
            for (int i = NCH - 1; i >= 0; i--) begin
                if (elig[i]) begin
                    gnt_any = 1'b1;
                    gnt_idx = CHW'(i);
                end
            end
        end else begin
            for (int k = NCH; k >= 1; k--) begin
                cand = last_q + CHW'(k);
                if (elig[cand]) begin
                    gnt_any = 1'b1;
                    gnt_idx = cand;
                end
            end
        end
    end

    // Expand the index into a one-hot grant.
    always_comb grant = gnt_any ? (NCH'(1) << gnt_idx) : '0;

    // Remember the most recent grant for rotation.
    always_ff @(posedge clk) begin
        if (!rst_n)       last_q <= CHW'(NCH - 1);
        else if (gnt_any) last_q <= gnt_idx;
    end

    assert_onehot_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    assert_grant_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~elig) == '0);
    assert_no_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|elig) |-> (|grant));
    assert_fixed_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!rr_mode && gnt_any) |-> ((elig & ((NCH'(1) << gnt_idx) - NCH'(1))) == '0));
endmodule

// File: rtl/sdma_channel.sv
// Module: sdma_channel
// Holds one channel's address, byte count, enables and completion flag,
// and advances them on each transferred byte. A software write to a field
// wins over the transfer update in the same cycle. Setting the flag wins
// over clearing it. Assumes DW >= AW >= CW.
module sdma_channel #(
    parameter int AW = 24,
    parameter int CW = 16,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_addr,
    input  logic          wr_cnt,
    input  logic          wr_ctrl,
    input  logic          clr_done,
    input  logic [DW-1:0] wdata,
    input  logic          xfer,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] cnt,
    output logic          en,
    output logic          ie,
    output logic          done
);
    logic last_byte;
    assign last_byte = xfer && (cnt == CW'(1));

    // Memory address: load from software or step after each byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr <= '0;
        else if (wr_addr) addr <= wdata[AW-1:0];
        else if (xfer)    addr <= addr + AW'(1);
    end

    // Byte count: load from software or count down after each byte.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (wr_cnt) cnt <= wdata[CW-1:0];
        else if (xfer)   cnt <= cnt - CW'(1);
    end

    // Enables: set by software, enable dropped on the last byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= 1'b0;
            ie <= 1'b0;
        end else if (wr_ctrl) begin
            en <= wdata[0];
            ie <= wdata[1];
        end else if (last_byte) begin
            en <= 1'b0;
        end
    end

    // Completion flag: set on the last byte, cleared by a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)         done <= 1'b0;
        else if (last_byte) done <= 1'b1;
        else if (clr_done)  done <= 1'b0;
    end

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !wr_addr) |=> (addr == $past(addr) + AW'(1)));
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && !wr_cnt) |=> (cnt == $past(cnt) - CW'(1)));
    assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer && cnt == CW'(1) && !wr_ctrl) |=> (!en && done));
    assert_off_no_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !xfer);
endmodule

// File: rtl/sdma4_ctrl.sv
// Module: sdma4_ctrl
// Four-channel single-address byte DMA. Even channels write receive data
// to memory and odd channels read memory for transmit. Only the memory
// address is driven, and the peripheral is selected by its acknowledge.
// Holds the register file, the arbiter and the interrupt output.
// Assumes NCH is a power of two and AW >= CW.
module sdma4_ctrl #(
    parameter int NCH = 4,
    parameter int AW  = 24,
    parameter int CW  = 16,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int RAW = CHW + 3,
    localparam int DW  = AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    input  logic [NCH-1:0] per_req,
    output logic [NCH-1:0] per_ack,
    output logic           mem_valid,
    output logic           mem_write,
    output logic [AW-1:0]  mem_addr,
    output logic           irq
);
    import sdma_pkg::*;

    localparam logic [NCH-1:0] RX_CH = NCH'(rx_mask(NCH));

    logic [AW-1:0]  ch_addr [NCH];
    logic [CW-1:0]  ch_cnt  [NCH];
    logic [NCH-1:0] ch_en, ch_ie, ch_done;
    logic [NCH-1:0] grant;
    logic [CHW-1:0] gnt_idx;
    logic           gnt_any;
    logic           rr_mode;
    logic           glb_sel;
    logic [CHW-1:0] ch_sel;
    logic [1:0]     ofs_sel;

    assign glb_sel = reg_addr[RAW-1];
    assign ch_sel  = reg_addr[CHW+1:2];
    assign ofs_sel = reg_addr[1:0];

    sdma_arbiter #(.NCH(NCH)) u_arb (
        .clk(clk), .rst_n(rst_n), .elig(per_req & ch_en), .rr_mode(rr_mode),
        .grant(grant), .gnt_idx(gnt_idx), .gnt_any(gnt_any)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = reg_we && !glb_sel && (ch_sel == CHW'(c));
        sdma_channel #(.AW(AW), .CW(CW), .DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .wr_addr(hit && ofs_sel == OFS_ADDR),
            .wr_cnt(hit && ofs_sel == OFS_CNT),
            .wr_ctrl(hit && ofs_sel == OFS_CTRL),
            .clr_done(reg_we && glb_sel && !reg_addr[0] && reg_wdata[c]),
            .wdata(reg_wdata), .xfer(grant[c]),
            .addr(ch_addr[c]), .cnt(ch_cnt[c]),
            .en(ch_en[c]), .ie(ch_ie[c]), .done(ch_done[c])
        );
    end

    // Priority mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             rr_mode <= 1'b0;
        else if (reg_we && glb_sel && reg_addr[0]) rr_mode <= reg_wdata[0];
    end

    // Bus outputs for the granted channel.
    always_comb begin
        per_ack   = grant;
        mem_valid = gnt_any;
        mem_write = gnt_any && RX_CH[gnt_idx];
        mem_addr  = ch_addr[gnt_idx];
        irq       = |(ch_done & ch_ie);
    end

    // Register read multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (glb_sel) begin
            reg_rdata = reg_addr[0] ? DW'(rr_mode) : DW'(ch_done);
        end else begin
            case (ofs_sel)
                OFS_ADDR: reg_rdata = DW'(ch_addr[ch_sel]);
                OFS_CNT:  reg_rdata = DW'(ch_cnt[ch_sel]);
                OFS_CTRL: reg_rdata = DW'({ch_ie[ch_sel], ch_en[ch_sel]});
                default:  reg_rdata = '0;
            endcase
        end
    end

    assert_direction_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_write == |(per_ack & RX_CH)));
    assert_single_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid == $onehot(per_ack));
    assert_ack_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (per_ack & ~per_req) == '0);
endmodule

// File: tb/test_sdma4_ctrl.sv
// Bench: random request and register traffic mixed with directed corner
// cases, compared every cycle against a bench-side channel model.
module test_sdma4_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [23:0] reg_wdata = '0;
    logic [23:0] reg_rdata;
    logic [3:0]  per_req = '0;
    logic [3:0]  per_ack;
    logic        mem_valid, mem_write, irq;
    logic [23:0] mem_addr;

    sdma4_ctrl i_sdma4_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
        .per_ack(per_ack), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .irq(irq)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [23:0] m_addr [4];
    logic [15:0] m_cnt  [4];
    bit          m_en [4], m_ie [4], m_done [4];
    int          m_last = 3;
    bit          m_rr = 0;
    logic [3:0]  obs_ack;
    int          n_ack3 = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int exp_grant(input logic [3:0] req);
        int g = -1;
        if (!m_rr) begin
            for (int i = 3; i >= 0; i--) if (req[i] && m_en[i]) g = i;
        end else begin
            for (int k = 4; k >= 1; k--) begin
                int c = (m_last + k) % 4;
                if (req[c] && m_en[c]) g = c;
            end
        end
        return g;
    endfunction

    function automatic logic exp_irq();
        logic r = 0;
        for (int i = 0; i < 4; i++) r |= m_done[i] & m_ie[i];
        return r;
    endfunction

    function automatic logic [23:0] exp_rd(input logic [4:0] a);
        int c = a[3:2];
        if (a[4]) return a[0] ? 24'(m_rr) : 24'({m_done[3], m_done[2], m_done[1], m_done[0]});
        case (a[1:0])
            2'd0: return m_addr[c];
            2'd1: return 24'(m_cnt[c]);
            2'd2: return 24'({m_ie[c], m_en[c]});
            default: return 24'd0;
        endcase
    endfunction

    // One bus cycle with the given requests, checked against the model.
    task automatic step(input logic [3:0] req);
        int g;
        @(negedge clk);
        reg_we = 0;
        per_req = req;
        #1;
        g = exp_grant(req);
        obs_ack = per_ack;
        if (per_ack[3]) n_ack3++;
        chk("R3 R9 R10 R11 ack", 32'(per_ack), (g < 0) ? 32'd0 : (32'd1 << g));
        chk("R3 valid", 32'(mem_valid), 32'(g >= 0));
        if (g >= 0) begin
            chk("R3 R4 addr", 32'(mem_addr), 32'(m_addr[g]));
            chk("R2 direction", 32'(mem_write), 32'(g % 2 == 0));
        end
        chk("R8 irq", 32'(irq), 32'(exp_irq()));
        if (g >= 0) begin
            if (m_cnt[g] == 16'd1) begin
                m_en[g] = 0;
                m_done[g] = 1;
            end
            m_addr[g] = m_addr[g] + 24'd1;
            m_cnt[g] = m_cnt[g] - 16'd1;
            m_last = g;
        end
        @(posedge clk);
    endtask

    // Register write with requests held low.
    task automatic wr(input logic [4:0] a, input logic [23:0] d);
        int c = a[3:2];
        @(negedge clk);
        per_req = 0;
        reg_we = 1;
        reg_addr = a;
        reg_wdata = d;
        @(posedge clk);
        if (a[4]) begin
            if (a[0]) m_rr = d[0];
            else for (int i = 0; i < 4; i++) if (d[i]) m_done[i] = 0;
        end else begin
            case (a[1:0])
                2'd0: m_addr[c] = d;
                2'd1: m_cnt[c] = d[15:0];
                2'd2: begin m_en[c] = d[0]; m_ie[c] = d[1]; end
                default: ;
            endcase
        end
        #1 reg_we = 0;
    endtask

    task automatic rd(input string tag, input logic [4:0] a);
        @(negedge clk);
        reg_we = 0;
        per_req = 0;
        reg_addr = a;
        #1 chk(tag, 32'(reg_rdata), 32'(exp_rd(a)));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int exp_c;
        void'($urandom(32'd4711));
        for (int i = 0; i < 4; i++) begin
            m_addr[i] = 0; m_cnt[i] = 0; m_en[i] = 0; m_ie[i] = 0; m_done[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R12: reset state
        for (int a = 0; a < 18; a++) rd("R12 reset read", 5'(a));
        step(4'hF);
        chk("R12 no ack after reset", 32'(obs_ack), 32'd0);

        // R1: readback of every field
        for (int c = 0; c < 4; c++) begin
            wr(5'(4 * c), 24'($urandom));
            wr(5'(4 * c + 1), 24'($urandom));
            wr(5'(4 * c + 2), 24'd2);
        end
        wr(5'd17, 24'd1);
        for (int a = 0; a < 18; a++) rd("R1 readback", 5'(a));
        wr(5'd17, 24'd0);

        // R4 R6: address wrap, completion, later requests ignored
        wr(5'd0, 24'hFFFFFE); wr(5'd1, 24'd3); wr(5'd2, 24'd3);
        repeat (3) step(4'b0001);
        rd("R6 done flag", 5'd16);
        chk("R8 irq with flag and enable", 32'(irq), 32'd1);
        repeat (2) step(4'b0001);
        chk("R6 ignored after finish", 32'(obs_ack), 32'd0);
        rd("R4 address wrapped", 5'd0);
        chk("R4 wrapped value", 32'(reg_rdata), 32'h000001);
        rd("R6 enable cleared", 5'd2);
        chk("R6 ctrl value", 32'(reg_rdata), 32'd2);

        // R7: write-one-to-clear
        wr(5'd16, 24'd0);
        rd("R7 zero write keeps flag", 5'd16);
        chk("R7 flag still set", 32'(reg_rdata[0]), 32'd1);
        wr(5'd16, 24'd1);
        rd("R7 one write clears", 5'd16);
        chk("R7 irq dropped", 32'(irq), 32'd0);

        // R8: flag without interrupt enable
        wr(5'd4, 24'h100); wr(5'd5, 24'd1); wr(5'd6, 24'd1);
        step(4'b0010);
        rd("R8 flag set", 5'd16);
        chk("R8 masked irq", 32'(irq), 32'd0);
        wr(5'd16, 24'hF);

        // R10: fixed order
        for (int c = 0; c < 4; c++) begin wr(5'(4 * c + 1), 24'd10); wr(5'(4 * c + 2), 24'd1); end
        repeat (3) begin step(4'hF); chk("R10 channel 0 wins", 32'(obs_ack), 32'd1); end
        step(4'b1100);
        chk("R10 channel 2 over 3", 32'(obs_ack), 32'd4);

        // R11: rotation
        wr(5'd17, 24'd1);
        for (int c = 0; c < 4; c++) begin wr(5'(4 * c + 1), 24'd10); wr(5'(4 * c + 2), 24'd1); end
        repeat (8) begin
            exp_c = (m_last + 1) % 4;
            step(4'hF);
            chk("R11 rotate", 32'(obs_ack), 32'd1 << exp_c);
        end
        exp_c = ((m_last + 1) % 2 == 0) ? (m_last + 1) % 4 : (m_last + 2) % 4;
        step(4'b0101);
        chk("R11 skip idle", 32'(obs_ack), 32'd1 << exp_c);

        // Random phase, R1 to R11
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 99);
            if (r < 85) step(4'($urandom));
            else if (r < 92) begin
                int c = $urandom_range(0, 3);
                int f = $urandom_range(0, 2);
                logic [23:0] d;
                d = (f == 0) ? 24'($urandom) : (f == 1) ? 24'($urandom_range(0, 6)) : 24'($urandom_range(0, 3));
                wr(5'(4 * c + f), d);
            end else if (r < 95) wr(5'(16 + $urandom_range(0, 1)), 24'($urandom_range(0, 15)));
            else rd("R1 random read", 5'($urandom_range(0, 17)));
        end

        // R5: count 0 means 65536 bytes
        wr(5'd17, 24'd0);
        for (int c = 0; c < 4; c++) wr(5'(4 * c + 2), 24'd0);
        wr(5'd16, 24'hF);
        wr(5'd12, 24'h0); wr(5'd13, 24'd0); wr(5'd14, 24'd1);
        n_ack3 = 0;
        repeat (65538) step(4'b1000);
        chk("R5 full block length", 32'(n_ack3), 32'd65536);
        rd("R5 enable cleared", 5'd14);
        rd("R5 address after block", 5'd12);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule